// File: doc/BRIEF.md
# Split Biquinary Decade Counter

This block is a four-bit counter made of two sections that share nothing except a clear. The lower section is a single divide-by-two stage that changes state on pulses at its own count input. The upper section is a group of three stages that divides by five and has its own count input. The two sections can run as two separate dividers. They can also be chained so that the four outputs count in BCD from 0 to 9.

Both count inputs are single-cycle enable pulses that are synchronous to one system clock. A chain-select input sets the mode. With chaining on, the divide-by-five group advances when the divide-by-two output falls from 1 to 0, and its own count input is ignored. With chaining off, each section counts only its own pulses. A shared clear acts only when both of its inputs are high at the same time. The lowest output bit is the divide-by-two stage. The upper three bits are the divide-by-five value, least significant bit first. In chained mode, output bit 3 completes one period for every ten input pulses.

Top module: `bq_decade_ctr`

## Requirements
- R1: While the system reset `rst` is high at a clock edge, `q_o` becomes 0000.
- R2: When `clr_a_i` and `clr_b_i` are both high at a clock edge, `q_o` becomes 0000. This clear wins over any count pulse in the same cycle.
- R3: When only one of `clr_a_i` and `clr_b_i` is high, nothing is cleared and counting goes on as if neither were high.
- R4: Bit `q_o[0]` inverts on every edge where `tick0_i` is high. In split mode (`chain_i`=0) it does not react to `tick1_i`.
- R5: In split mode, `q_o[3:1]` (bit 1 is the least significant) advances 0,1,2,3,4,0 on every edge where `tick1_i` is high, and does not react to `tick0_i`.
- R6: In chained mode (`chain_i`=1), each `tick0_i` pulse adds one to the binary value of `q_o`, modulo 10. After a pulse at value 9 the value is 0.
- R7: In chained mode, `tick1_i` has no effect on `q_o`.
- R8: In a cycle with no count pulse that takes effect and no clear, `q_o` keeps its value.
- R9: In chained mode, `q_o[3]` is high exactly for counts 8 and 9. It therefore goes through one full period every ten `tick0_i` pulses.
- R10: The value in `q_o[3:1]` is never greater than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick0_i | input | 1 | Count pulse for the divide-by-two stage |
| tick1_i | input | 1 | Count pulse for the divide-by-five group (split mode only) |
| clr_a_i | input | 1 | First input of the two-input clear |
| clr_b_i | input | 1 | Second input of the two-input clear |
| chain_i | input | 1 | 1 = divide-by-five group clocked by the falling edge of bit 0 |
| q_o | output | 4 | Counter state; bit 0 is the divide-by-two stage |

## Verification
The bench targets four corner cases:
- The 9-to-0 wrap in chained mode. A design that picked up the carry on the rising edge of bit 0, or one cycle late, would skip values or show 10 to 15.
- One clear input held high alone. A design that OR-ed the two clear inputs would zero the counter.
- A clear that arrives together with count pulses. A design without clear priority would show 0001 or a non-zero upper value afterwards.
- Pulses on the count input that should be ignored, in each mode. A design that let them through would change the count in the other section, or would advance the upper group twice in one cycle when chained.

Expected values come from a running count kept modulo 2, modulo 5 and modulo 10 in the bench.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int unsigned BQ_LO_MOD = 2;
  localparam int unsigned BQ_HI_MOD = 5;
  localparam int unsigned BQ_HI_W   = $clog2(BQ_HI_MOD);
  localparam int unsigned BQ_Q_W    = 1 + BQ_HI_W;

  typedef enum logic {
    BQ_SPLIT = 1'b0,
    BQ_CHAIN = 1'b1
  } bq_mode_e;
endpackage

// File: rtl/bq_toggle_stage.sv
module bq_toggle_stage (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (en)    q <= ~q;
  end

  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (q != $past(q)));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/bq_quinary_stage.sv
module bq_quinary_stage #(
  parameter int unsigned MOD = 5,
  localparam int unsigned W  = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] q_next;

  always_comb begin
    if (q == LAST) q_next = '0;
    else           q_next = q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (adv)   q <= q_next;
  end

  p_range_r10: assert property (@(posedge clk) disable iff (rst)
    q <= LAST);
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && q == LAST) |=> (q == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(q));
endmodule

// File: rtl/bq_decade_ctr.sv
module bq_decade_ctr
  import bq_pkg::*;
#(
  parameter int unsigned HI_MOD = BQ_HI_MOD,
  localparam int unsigned HI_W  = $clog2(HI_MOD),
  localparam int unsigned Q_W   = 1 + HI_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick0_i,
  input  logic           tick1_i,
  input  logic           clr_a_i,
  input  logic           clr_b_i,
  input  logic           chain_i,
  output logic [Q_W-1:0] q_o
);
  localparam logic [Q_W-1:0] TOP_VAL = {HI_W'(HI_MOD - 1), 1'b1};

  bq_mode_e          mode;
  logic              clr_both;
  logic              lo_q;
  logic              lo_falls;
  logic              hi_adv;
  logic [HI_W-1:0]   hi_q;

  assign mode     = bq_mode_e'(chain_i);
  assign clr_both = clr_a_i & clr_b_i;
  // the low stage falls 1 -> 0 on this edge exactly when it is 1 and pulsed
  assign lo_falls = tick0_i & lo_q;

  always_comb begin
    unique case (mode)
      BQ_CHAIN: hi_adv = lo_falls;
      default:  hi_adv = tick1_i;
    endcase
  end

  bq_toggle_stage u_lo (
    .clk (clk),
    .rst (rst),
    .clr (clr_both),
    .en  (tick0_i),
    .q   (lo_q)
  );

  bq_quinary_stage #(.MOD(HI_MOD)) u_hi (
    .clk (clk),
    .rst (rst),
    .clr (clr_both),
    .adv (hi_adv),
    .q   (hi_q)
  );

  assign q_o = {hi_q, lo_q};

  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_a_i && clr_b_i) |=> (q_o == '0));
  p_chain_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (chain_i && tick0_i && !clr_both && q_o == TOP_VAL) |=> (q_o == '0));
  p_chain_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (chain_i && !tick0_i && !clr_both) |=> $stable(q_o));
  p_split_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (!chain_i && !tick0_i && !clr_both) |=> $stable(q_o[0]));
endmodule

// File: tb/test_bq_decade_ctr.sv
module test_bq_decade_ctr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick0 = 1'b0, tick1 = 1'b0, clr_a = 1'b0, clr_b = 1'b0, chain = 1'b0;
  logic [3:0] q;

  int total = 0;
  int bad   = 0;
  int m_lo  = 0;
  int m_hi  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  bq_decade_ctr i_bq_decade_ctr (
    .clk(clk), .rst(rst), .tick0_i(tick0), .tick1_i(tick1),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .chain_i(chain), .q_o(q)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected %b", req, act, exp);
    end
  endtask

  // apply one cycle of inputs, update the reference model, compare after the edge
  task automatic cyc(input logic t0, input logic t1, input logic ca,
                     input logic cb, input logic ch, input string req);
    int adv;
    tick0 = t0; tick1 = t1; clr_a = ca; clr_b = cb; chain = ch;
    @(posedge clk);
    #1;
    if (rst || (ca && cb)) begin
      m_lo = 0; m_hi = 0;
    end else begin
      adv = ch ? int'(t0 && m_lo == 1) : int'(t1);
      if (t0) m_lo = 1 - m_lo;
      if (adv != 0) m_hi = (m_hi + 1) % 5;
    end
    chk(req, q, 4'(m_hi * 2 + m_lo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: q=%b expected completion", q);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(1, 1, 0, 0, 0, "R1");
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, "R8");

    // split mode sweep over all pulse combinations (R4, R5, R10)
    for (int i = 0; i < 40; i++)
      cyc(i[0], i[1] ^ i[3], 0, 0, 0, "R4/R5");
    for (int i = 0; i < 12; i++) begin
      cyc(0, 1, 0, 0, 0, "R5");
      chk("R10", {1'b0, q[3:1] > 3'd4 ? 3'd7 : 3'd0}, 4'd0);
    end
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, "R8");

    // clear needs both inputs (R2, R3)
    cyc(1, 1, 1, 0, 0, "R3");
    cyc(1, 1, 0, 1, 0, "R3");
    cyc(1, 1, 1, 1, 0, "R2");
    chk("R2", q, 4'd0);

    // chained decade counting with tick1 noise (R6, R7, R9)
    for (int i = 1; i <= 35; i++) begin
      cyc(1, i[0], 0, 0, 1, "R6");
      chk("R6", q, 4'(i % 10));
      chk("R9", {3'b0, q[3]}, {3'b0, (i % 10) >= 8});
      cyc(0, 1, 0, 0, 1, "R7");
    end
    cyc(1, 0, 1, 0, 1, "R3");
    cyc(1, 1, 0, 1, 1, "R3");
    cyc(1, 1, 1, 1, 1, "R2");
    chk("R2", q, 4'd0);

    // mode change with state mid-count
    for (int i = 0; i < 20; i++) cyc(i[0] | i[2], i[1], 0, 0, i[3], "R4/R5/R6");

    rst = 1'b1;
    cyc(1, 1, 0, 0, 1, "R1");
    chk("R1", q, 4'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule